// File: doc/BRIEF.md
# Time-Protected Configuration Register

This block holds one 8-bit system configuration byte behind a simple single-cycle write strobe and a continuously driven read bus. Three of its fields are open to software at all times. A protected group of four fields may be written only during a short window that opens when reset is released, and only once: the first write inside the window closes the group for the rest of the session. A special-mode input lifts this protection, so test or boot code can rewrite the protected fields freely.

Two fields of the byte drive local behaviour. One selects how the active-low interrupt input is conditioned: it is passed through as a level, or falling edges are caught in a pending flag that software acknowledges. The other enables a clock monitor. When a clock-stop request arrives while monitoring is on, the block emits a one-cycle reset request. Software can use this to force a reset on purpose. The remaining fields (converter power-up, converter clock choice, oscillator delay, two rate-select bits) are only stored and read back.

Top module: `cfg_guard_reg`

## Requirements
- R1: After reset the byte reads 0x10. Only bit 4 (oscillator delay enable) is 1. irqReq is 0 while irqN is high, and rstReq is 0.
- R2: Bits 7 (converter power-up), 6 (converter clock choice) and 3 (clock monitor enable) take the written value on every write, in either mode.
- R3: Bit 2 always reads 0. Writing 1 to it has no effect.
- R4: In normal mode (specialMode=0), the protected bits 5 (interrupt edge mode), 4, 1 and 0 (rate select) take the written value only on a write sampled at one of the first 64 rising edges after reset is released (edges 0 to 63). Any write inside that window locks them, and later writes leave them unchanged.
- R5: In normal mode, a write sampled at edge 64 or later leaves the protected bits unchanged, even when no write landed in the window.
- R6: With specialMode=1, the protected bits take the written value on every write, at any time and any number of times.
- R7: With bit 5 at 0 (level mode), irqReq equals the inverse of irqN within the same cycle.
- R8: With bit 5 at 1 (edge mode), irqN sampled high at one edge and low at the next sets a pending flag. irqReq shows that flag. irqAck sampled high clears it, and a new falling edge wins over a simultaneous acknowledge.
- R9: When stopReq is sampled rising (0 at the previous edge, 1 now) while bit 3 is 1, rstReq is high for exactly the following cycle. With bit 3 at 0 no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| specialMode | input | 1 | 1 lifts write protection of the protected bits |
| wrEn | input | 1 | Write strobe, one write per cycle it is high |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Current configuration byte |
| irqN | input | 1 | Active-low interrupt input |
| irqAck | input | 1 | Clears the pending flag in edge mode |
| irqReq | output | 1 | Conditioned interrupt request |
| stopReq | input | 1 | Clock-stop request |
| rstReq | output | 1 | One-cycle reset request |

## Verification
The assertions take for granted that irqN, irqAck, stopReq and specialMode are already synchronous to clk. They also assume a write is a level sampled at each rising edge, not a handshake. A held stopReq therefore counts as one request, and a held irqN low counts as one edge. The stimulus changes every input only at falling clock edges. It starts every window test from a fresh reset, so the bench's own edge count after release matches the design's window count.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

  localparam int CFG_W = 8;

  // bits written at any time: converter power-up, converter clock, monitor enable
  localparam logic [CFG_W-1:0] FREE_MASK  = 8'hC8;
  // write-once group: edge mode, delay enable, rate select pair
  localparam logic [CFG_W-1:0] PROT_MASK  = 8'h33;
  localparam logic [CFG_W-1:0] RESET_VAL  = 8'h10;

  localparam int EDGE_MODE_BIT = 5;
  localparam int MON_EN_BIT    = 3;
  localparam int SPARE_BIT     = 2;

  typedef struct packed {
    logic freeWr;     // update the always-open bits
    logic protWr;     // update the protected group
    logic pendSet;    // falling edge seen in edge mode
    logic pendClr;    // acknowledge or level mode
    logic resetFire;  // launch a reset request
  } ctlStrobe_t;

endpackage

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl
  import cfg_guard_pkg::*;
#(
  parameter int WINDOW_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       specialMode,
  input  logic       wrEn,
  input  logic       irqN,
  input  logic       irqAck,
  input  logic       edgeMode,
  input  logic       stopReq,
  input  logic       monitorEn,
  output ctlStrobe_t strobe
);

  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] WIN_END = CNT_W'(WINDOW_CYCLES);

  logic [CNT_W-1:0] cycCount;
  logic             windowOpen;
  logic             lockFlag;
  logic             irqPrev;
  logic             stopPrev;

  assign windowOpen = (cycCount != WIN_END);

  // saturating post-reset counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCount <= '0;
    end else if (windowOpen) begin
      cycCount <= cycCount + 1'b1;
    end
  end

  // sticky lock: the first write inside the window closes the group
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockFlag <= 1'b0;
    end else if (wrEn && windowOpen) begin
      lockFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPrev  <= 1'b1;
      stopPrev <= 1'b0;
    end else begin
      irqPrev  <= irqN;
      stopPrev <= stopReq;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.freeWr    = wrEn;
    strobe.protWr    = wrEn && (specialMode || (windowOpen && !lockFlag));
    strobe.pendSet   = edgeMode && irqPrev && !irqN;
    strobe.pendClr   = irqAck || !edgeMode;
    strobe.resetFire = monitorEn && stopReq && !stopPrev;
  end

  assert_window_shut_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!specialMode && cycCount == WIN_END) |-> !strobe.protWr);

  assert_lock_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!specialMode && lockFlag) |-> !strobe.protWr);

  assert_count_sat_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cycCount == WIN_END) |=> (cycCount == WIN_END));

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag |=> lockFlag);

endmodule

// File: rtl/cfg_guard_dp.sv
module cfg_guard_dp
  import cfg_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [CFG_W-1:0] wrData,
  input  logic             irqN,
  output logic [CFG_W-1:0] rdData,
  output logic             edgeMode,
  output logic             monitorEn,
  output logic             irqReq,
  output logic             rstReq
);

  logic [CFG_W-1:0] cfgReg;
  logic [CFG_W-1:0] nextReg;
  logic             pending;
  logic             rstReqQ;

  always_comb begin
    nextReg = cfgReg;
    if (strobe.freeWr) begin
      nextReg = (nextReg & ~FREE_MASK) | (wrData & FREE_MASK);
    end
    if (strobe.protWr) begin
      nextReg = (nextReg & ~PROT_MASK) | (wrData & PROT_MASK);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= RESET_VAL;
    end else begin
      cfgReg <= nextReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strobe.pendSet) begin
      pending <= 1'b1;
    end else if (strobe.pendClr) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReqQ <= 1'b0;
    end else begin
      rstReqQ <= strobe.resetFire;
    end
  end

  assign rdData    = cfgReg;
  assign edgeMode  = cfgReg[EDGE_MODE_BIT];
  assign monitorEn = cfgReg[MON_EN_BIT];
  assign irqReq    = edgeMode ? pending : !irqN;
  assign rstReq    = rstReqQ;

  assert_spare_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdData[SPARE_BIT] == 1'b0);

  assert_prot_guard_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.protWr |=> $stable(cfgReg & PROT_MASK));

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstReqQ |=> !rstReqQ);

  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !strobe.pendClr) |=> pending);

endmodule

// File: rtl/cfg_guard_reg.sv
module cfg_guard_reg
  import cfg_guard_pkg::*;
#(
  parameter int WINDOW_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       specialMode,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       irqN,
  input  logic       irqAck,
  output logic       irqReq,
  input  logic       stopReq,
  output logic       rstReq
);

  ctlStrobe_t strobe;
  logic       edgeMode;
  logic       monitorEn;

  cfg_guard_ctrl #(.WINDOW_CYCLES(WINDOW_CYCLES)) ctrlInst (
    .clk         (clk),
    .rstN        (rstN),
    .specialMode (specialMode),
    .wrEn        (wrEn),
    .irqN        (irqN),
    .irqAck      (irqAck),
    .edgeMode    (edgeMode),
    .stopReq     (stopReq),
    .monitorEn   (monitorEn),
    .strobe      (strobe)
  );

  cfg_guard_dp dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .irqN      (irqN),
    .rdData    (rdData),
    .edgeMode  (edgeMode),
    .monitorEn (monitorEn),
    .irqReq    (irqReq),
    .rstReq    (rstReq)
  );

endmodule

// File: tb/cfg_guard_reg_test.sv
`timescale 1ns/1ps
module cfg_guard_reg_test;

  localparam logic [7:0] FREE = 8'hC8;
  localparam logic [7:0] PROT = 8'h33;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       specialMode = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irqN = 1'b1;
  logic       irqAck = 1'b0;
  logic       irqReq;
  logic       stopReq = 1'b0;
  logic       rstReq;

  int total = 0;
  int bad = 0;
  int edgeIdx = 0;
  logic [7:0] expReg;
  bit lockExp;
  bit pendExp;
  bit prevExp;
  bit pendNext;

  cfg_guard_reg uut (
    .clk(clk), .rstN(rstN), .specialMode(specialMode), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irqN(irqN), .irqAck(irqAck),
    .irqReq(irqReq), .stopReq(stopReq), .rstReq(rstReq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) edgeIdx <= 0;
    else edgeIdx <= edgeIdx + 1;
  end

  function automatic logic [7:0] applyWrite(input logic [7:0] old,
                                            input logic [7:0] d,
                                            input bit protOk);
    logic [7:0] r;
    r = (old & ~FREE) | (d & FREE);
    if (protOk) r = (r & ~PROT) | (d & PROT);
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; irqN = 1'b1; irqAck = 1'b0; stopReq = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expReg = 8'h10;
    lockExp = 1'b0;
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic busWrite(input logic [7:0] d);
    int idx;
    bit ok;
    idx = edgeIdx;
    ok = specialMode || (idx < 64 && !lockExp);
    if (idx < 64) lockExp = 1'b1;
    expReg = applyWrite(expReg, d, ok);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idleUntil(input int n);
    while (edgeIdx != n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    doReset();
    #1;
    check("R1 reset value", rdData, 8'h10);
    check("R1 irqReq idle", {7'd0, irqReq}, 8'h0);
    check("R1 rstReq idle", {7'd0, rstReq}, 8'h0);

    @(negedge clk);
    busWrite(8'hFF);
    check("R4 first write in window / R3 spare bit", rdData, expReg);
    check("R3 spare reads zero", {7'd0, rdData[2]}, 8'h0);
    busWrite(8'h00);
    check("R4 locked after first write", rdData, expReg);
    check("R4 locked value", rdData, 8'h33);
    for (int i = 0; i < 20; i++) begin
      busWrite(8'($urandom));
      check("R2 free bits normal mode", rdData, expReg);
    end

    doReset();
    idleUntil(63);
    busWrite(8'h23);
    check("R4 write at last window edge", rdData, 8'h23);

    doReset();
    idleUntil(64);
    busWrite(8'hFF);
    check("R5 write at edge 64 ignored", rdData, 8'hD8);
    idleUntil(100);
    busWrite(8'h33);
    check("R5 late write ignored", rdData, 8'h10);

    specialMode = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      busWrite(8'($urandom));
      check("R6 special mode write", rdData, expReg);
    end

    busWrite(8'h00);
    irqN = 1'b0; #1;
    check("R7 level low", {7'd0, irqReq}, 8'h1);
    irqN = 1'b1; #1;
    check("R7 level high", {7'd0, irqReq}, 8'h0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      irqN = 1'($urandom); #1;
      check("R7 level follow", {7'd0, irqReq}, {7'd0, !irqN});
    end
    irqN = 1'b1;
    @(negedge clk);

    busWrite(8'h20);
    check("R8 edge mode idle", {7'd0, irqReq}, 8'h0);
    irqN = 1'b0; #1;
    check("R8 no request before edge sampled", {7'd0, irqReq}, 8'h0);
    @(negedge clk);
    check("R8 pending after falling edge", {7'd0, irqReq}, 8'h1);
    irqN = 1'b1;
    @(negedge clk);
    check("R8 pending held", {7'd0, irqReq}, 8'h1);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    check("R8 ack clears", {7'd0, irqReq}, 8'h0);
    irqN = 1'b0; irqAck = 1'b1;
    @(negedge clk);
    check("R8 set wins over ack", {7'd0, irqReq}, 8'h1);
    irqN = 1'b1; irqAck = 1'b0;
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    pendExp = 1'b0; prevExp = 1'b1;
    for (int i = 0; i < 40; i++) begin
      irqN = 1'($urandom);
      irqAck = (($urandom % 4) == 0);
      pendNext = (prevExp && !irqN) ? 1'b1 : (irqAck ? 1'b0 : pendExp);
      prevExp = irqN;
      pendExp = pendNext;
      @(negedge clk);
      check("R8 random edge stream", {7'd0, irqReq}, {7'd0, pendExp});
    end
    irqN = 1'b1; irqAck = 1'b0;
    @(negedge clk);

    busWrite(8'h08);
    stopReq = 1'b1; #1;
    check("R9 no pulse before edge", {7'd0, rstReq}, 8'h0);
    @(negedge clk);
    check("R9 pulse after stop", {7'd0, rstReq}, 8'h1);
    @(negedge clk);
    check("R9 pulse lasts one cycle", {7'd0, rstReq}, 8'h0);
    stopReq = 1'b0;
    @(negedge clk);
    busWrite(8'h00);
    stopReq = 1'b1;
    @(negedge clk);
    check("R9 no pulse with monitor off", {7'd0, rstReq}, 8'h0);
    @(negedge clk);
    check("R9 still no pulse", {7'd0, rstReq}, 8'h0);
    stopReq = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule